// File: doc/BRIEF.md
# Triggered Dual-Channel Capture Controller

This block sits between a time-multiplexed two-channel sample stream and an on-chip dual-port waveform buffer of 1024 entries. Every incoming sample is 12 bits wide, and only its top 8 bits matter. A channel-1 sample rising above a host-programmed level starts a capture. The comparator carries a programmable hysteresis band, so a glitch near the level cannot retrigger it. A trigger is accepted only after the signal has dropped clearly below the level.

A capture fills the whole buffer with the samples that follow the trigger. Channel 2 goes to even addresses and channel 1 to odd ones. Triggers that arrive while the buffer is being written are discarded. A mode pin decides what happens when a capture ends: the block either freezes the buffer or re-arms for the next trigger. If the block stays armed for a host-set number of buffer-lengths without a trigger, it writes zeros over the whole buffer, which gives a flat baseline trace.

Top module: `scope_capture_ctrl`

## Requirements
- R1: A channel-1 sample fires the trigger when its top 8 bits are strictly greater than the level register (selector 0) and the comparator is armed. A fire seen while idle makes `busy` high from the next cycle.
- R2: The comparator becomes armed when a channel-1 sample plus the hysteresis register (selector 1) is strictly less than the level. A fire clears it, and so does reset. A sample inside the band leaves it unchanged.
- R3: Only bits 11..4 of `smp_data` are compared and stored. Channel-2 samples (`smp_ch2`=1) never fire the trigger.
- R4: A capture writes exactly 1024 entries at ascending addresses 0 to 1023. It starts with the first sample after the trigger sample. Each write appears on the memory port one cycle after its sample, and the first busy cycle carries no write.
- R5: During a capture, a channel-1 sample is written to an odd address and a channel-2 sample to an even address. Bit 0 of the address is the inverse of `smp_ch2`.
- R6: Trigger conditions that occur during a capture are ignored. They neither restart the capture nor add writes after address 1023.
- R7: With `hold_mode` low, `busy` and `done` are both low right after the last write, and the next trigger starts a new capture.
- R8: With `hold_mode` high, `done` goes high after a capture and no writes occur while it stays high. Once `hold_mode` goes low, the block re-arms.
- R9: After the miss limit of 1024-sample periods with no trigger while armed, the block writes zero to addresses 0 to 1023, one per clock. `busy` stays high during this fill.
- R10: The miss limit register (selector 2) resets to 4. Writing 0 to it disables the zero fill. Only valid samples received while armed advance the period count.
- R11: After reset, `mem_we`, `busy` and `done` are low, and the comparator is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_ch2 | input | 1 | Sample belongs to channel 2 (0 = channel 1) |
| smp_data | input | 12 | Converter sample |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 2 | Register selector: 0 level, 1 hysteresis, 2 miss limit |
| cfg_wdata | input | 8 | Host register write data |
| hold_mode | input | 1 | High: freeze after one capture; low: repeat |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | 10 | Buffer write address |
| mem_wdata | output | 8 | Buffer write data |
| busy | output | 1 | Capture or zero fill in progress |
| done | output | 1 | Capture frozen in single mode |

## Verification
The trigger is driven with short channel-1 sequences. Each sequence is chosen so that only one cause can separate fire from no-fire: a sample equal to the level, a dip that stays inside the hysteresis band, a dip just below it, a band wider than the level, and a loud channel 2. Full captures use a channel-1 ramp that keeps crossing the level. The two channels carry different data, and each sample has non-zero low bits. Together these expose masking errors, swapped parity, off-by-one start or end addresses, and wrong bit selection. The zero fill is run at a limit of one period, at the reset default, one sample short of the default, and with the limit disabled, which pins down the exact sample count at which the fill starts.

// File: rtl/scope_cap_pkg.sv
package scope_cap_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_CAPT  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_FILL  = 2'd3
  } cap_st_e;

  localparam logic [1:0] CFG_LEVEL = 2'd0;
  localparam logic [1:0] CFG_HYST  = 2'd1;
  localparam logic [1:0] CFG_LIMIT = 2'd2;

endpackage

// File: rtl/scope_trig_schmitt.sv
module scope_trig_schmitt #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_is_ch1,
  input  logic [DATA_W-1:0] smp_hi,
  input  logic [DATA_W-1:0] level,
  input  logic [DATA_W-1:0] hyst,
  output logic              fire
);

  logic            armed_q, armed_d;
  logic [DATA_W:0] low_sum;
  logic            below_band, above_lvl, sample_en;

  assign sample_en  = smp_valid & smp_is_ch1;
  assign low_sum    = {1'b0, smp_hi} + {1'b0, hyst};
  assign below_band = low_sum < {1'b0, level};
  assign above_lvl  = smp_hi > level;
  assign fire       = sample_en & armed_q & above_lvl;

  always_comb begin
    armed_d = armed_q;
    if (sample_en) begin
      if (fire)            armed_d = 1'b0;
      else if (below_band) armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R2
  disarm_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q);

endmodule

// File: rtl/scope_miss_timer.sv
module scope_miss_timer #(
  parameter int PER_W = 10,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             clear,
  input  logic [LIM_W-1:0] limit,
  output logic             timeout
);

  logic [PER_W-1:0] per_q, per_d;
  logic [LIM_W-1:0] miss_q, miss_d;
  logic [LIM_W:0]   miss_inc;
  logic             wrap;

  assign wrap     = count_en & (&per_q);
  assign miss_inc = {1'b0, miss_q} + 1'b1;
  assign timeout  = wrap & (limit != '0) & (miss_inc >= {1'b0, limit});

  always_comb begin
    per_d  = per_q;
    miss_d = miss_q;
    if (clear || timeout) begin
      per_d  = '0;
      miss_d = '0;
    end else if (count_en) begin
      per_d = per_q + 1'b1;
      if (wrap && !(&miss_q)) miss_d = miss_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      miss_q <= '0;
    end else begin
      per_q  <= per_d;
      miss_q <= miss_d;
    end
  end

  // R10
  no_fill_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !timeout);

endmodule

// File: rtl/scope_capture_seq.sv
module scope_capture_seq
  import scope_cap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_ch2,
  input  logic [DATA_W-1:0] smp_hi,
  input  logic              fire,
  input  logic              timeout,
  input  logic              hold,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              armed
);

  cap_st_e           st_q, st_d, end_st;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              wen_q, wen_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              pair_last, fill_last;

  assign end_st    = hold ? ST_HOLD : ST_ARMED;
  assign pair_last = &cnt_q[ADDR_W-1:1];
  assign fill_last = &cnt_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    wen_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    unique case (st_q)
      ST_ARMED: begin
        if (fire) begin
          st_d  = ST_CAPT;
          cnt_d = '0;
        end else if (timeout) begin
          st_d  = ST_FILL;
          cnt_d = '0;
        end
      end
      ST_CAPT: begin
        if (smp_valid) begin
          wen_d   = 1'b1;
          waddr_d = {cnt_q[ADDR_W-1:1], ~smp_ch2};
          wdata_d = smp_hi;
          if (!smp_ch2) begin
            if (pair_last) st_d = end_st;
            else           cnt_d = cnt_q + ADDR_W'(2);
          end
        end
      end
      ST_FILL: begin
        wen_d   = 1'b1;
        waddr_d = cnt_q;
        wdata_d = '0;
        cnt_d   = cnt_q + 1'b1;
        if (fill_last) st_d = end_st;
      end
      ST_HOLD: begin
        if (!hold) st_d = ST_ARMED;
      end
      default: st_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_ARMED;
      cnt_q   <= '0;
      wen_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      wen_q   <= wen_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign wr_en   = wen_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;
  assign busy    = (st_q == ST_CAPT) | (st_q == ST_FILL);
  assign done    = (st_q == ST_HOLD);
  assign armed   = (st_q == ST_ARMED);

  // R5
  parity_by_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAPT && smp_valid) |=> (wen_q && (waddr_q[0] == !$past(smp_ch2))));

  // R4
  quiet_while_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED) |=> !wen_q);

  // R8
  quiet_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |=> !wen_q);

  // R9
  zero_fill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL) |=> (wen_q && wdata_q == '0));

endmodule

// File: rtl/scope_capture_ctrl.sv
module scope_capture_ctrl
  import scope_cap_pkg::*;
#(
  parameter int          SMP_W     = 12,
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 10,
  parameter int          LIM_W     = 8,
  parameter logic [7:0]  DEF_LEVEL = 8'h80,
  parameter logic [7:0]  DEF_HYST  = 8'h04,
  parameter logic [7:0]  DEF_LIMIT = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_ch2,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              hold_mode,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);

  function automatic logic [DATA_W-1:0] top_bits(input logic [SMP_W-1:0] v);
    return v[SMP_W-1 -: DATA_W];
  endfunction

  logic [DATA_W-1:0] level_q, level_d;
  logic [DATA_W-1:0] hyst_q, hyst_d;
  logic [LIM_W-1:0]  limit_q, limit_d;
  logic [DATA_W-1:0] smp_hi;
  logic              fire, timeout, armed, accept;

  assign smp_hi = top_bits(smp_data);
  assign accept = armed & fire;

  always_comb begin
    level_d = level_q;
    hyst_d  = hyst_q;
    limit_d = limit_q;
    if (cfg_we) begin
      unique case (cfg_sel)
        CFG_LEVEL: level_d = cfg_wdata;
        CFG_HYST:  hyst_d  = cfg_wdata;
        CFG_LIMIT: limit_d = LIM_W'(cfg_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= DATA_W'(DEF_LEVEL);
      hyst_q  <= DATA_W'(DEF_HYST);
      limit_q <= LIM_W'(DEF_LIMIT);
    end else begin
      level_q <= level_d;
      hyst_q  <= hyst_d;
      limit_q <= limit_d;
    end
  end

  scope_trig_schmitt #(.DATA_W(DATA_W)) i_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_is_ch1 (~smp_ch2),
    .smp_hi     (smp_hi),
    .level      (level_q),
    .hyst       (hyst_q),
    .fire       (fire)
  );

  scope_miss_timer #(.PER_W(ADDR_W), .LIM_W(LIM_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (armed & smp_valid),
    .clear    (accept),
    .limit    (limit_q),
    .timeout  (timeout)
  );

  scope_capture_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ch2   (smp_ch2),
    .smp_hi    (smp_hi),
    .fire      (fire),
    .timeout   (timeout),
    .hold      (hold_mode),
    .wr_en     (mem_we),
    .wr_addr   (mem_addr),
    .wr_data   (mem_wdata),
    .busy      (busy),
    .done      (done),
    .armed     (armed)
  );

  // R4
  no_write_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mem_we);

endmodule

// File: tb/test_scope_capture_ctrl.sv
module test_scope_capture_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ch2 = 1'b0;
  logic [11:0] smp_data = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic       hold_mode = 1'b0;
  logic       mem_we;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       busy, done;

  always #10 clk = ~clk;

  scope_capture_ctrl i_scope_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ch2(smp_ch2),
    .smp_data(smp_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hold_mode(hold_mode), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done)
  );

  typedef struct packed {
    logic [7:0] lvl;
    logic [7:0] hys;
    logic [7:0] s0;
    logic [7:0] s1;
    logic [7:0] s2;
    logic       exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd100, 8'd10, 8'd50,  8'd60,  8'd101, 1'b1},
    '{8'd100, 8'd10, 8'd95,  8'd101, 8'd120, 1'b0},
    '{8'd100, 8'd10, 8'd89,  8'd101, 8'd0,   1'b1},
    '{8'd100, 8'd0,  8'd99,  8'd101, 8'd0,   1'b1},
    '{8'd100, 8'd0,  8'd100, 8'd100, 8'd101, 1'b0},
    '{8'd10,  8'd20, 8'd0,   8'd200, 8'd200, 1'b0},
    '{8'd254, 8'd0,  8'd0,   8'd255, 8'd0,   1'b1},
    '{8'd100, 8'd10, 8'd50,  8'd60,  8'd70,  1'b0}
  };

  int n_chk = 0;
  int n_fail = 0;
  int wr_total = 0;
  int mon_err = 0;
  int wr_base = 0;
  logic fill_mode = 1'b0;
  int cyc = 0;

  function automatic logic [7:0] f1(input int p);
    return 8'((p * 5) & 255);
  endfunction
  function automatic logic [7:0] f2(input int p);
    return 8'((p * 3 + 1) & 255);
  endfunction

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (int'(mem_addr) != ((wr_total - wr_base) & 1023)) mon_err++;
      if (fill_mode) begin
        if (mem_wdata != 8'd0) mon_err++;
      end else if (mem_addr[0]) begin
        if (mem_wdata != f1(int'(mem_addr) >> 1)) mon_err++;
      end else begin
        if (mem_wdata != f2(int'(mem_addr) >> 1)) mon_err++;
      end
      wr_total++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    cfg_we = 1'b0;
    hold_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic ch2, input logic [7:0] val, input logic [3:0] lo);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_ch2 = ch2;
    smp_data = {val, lo};
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic mark();
    wr_base = wr_total;
    mon_err = 0;
  endtask

  task automatic run_capture();
    for (int p = 0; p < 512; p++) begin
      push(1'b1, f2(p), 4'hA);
      push(1'b0, f1(p), 4'h5);
    end
  endtask

  initial begin
    do_reset();
    @(posedge clk);
    #2;
    // R11 reset state
    chk("R11 mem_we", int'(mem_we), 0);
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);

    // R1 R2 R3 trigger table
    foreach (VECS[i]) begin
      do_reset();
      cfg(2'd0, VECS[i].lvl);
      cfg(2'd1, VECS[i].hys);
      push(1'b0, VECS[i].s0, 4'hF); push(1'b1, 8'd255, 4'hF);
      push(1'b0, VECS[i].s1, 4'hF); push(1'b1, 8'd255, 4'hF);
      push(1'b0, VECS[i].s2, 4'hF); push(1'b1, 8'd255, 4'hF);
      idle();
      chk($sformatf("R1 R2 R3 vector %0d busy", i), int'(busy), int'(VECS[i].exp));
    end

    // R4 R5 R6 R7 full capture in repeat mode
    do_reset();
    cfg(2'd0, 8'd100);
    cfg(2'd1, 8'd10);
    fill_mode = 1'b0;
    push(1'b0, 8'd0, 4'h0);
    chk("R11 R1 no fire on low", int'(busy), 0);
    push(1'b0, 8'd200, 4'h0);
    chk("R1 busy after fire", int'(busy), 1);
    mark();
    run_capture();
    chk("R7 busy after last write", int'(busy), 0);
    chk("R7 done in repeat mode", int'(done), 0);
    idle();
    @(posedge clk); #2;
    chk("R4 write count", wr_total - wr_base, 1024);
    chk("R3 R4 R5 address and data", mon_err, 0);
    repeat (4) @(posedge clk);
    #2;
    chk("R6 no writes after masked triggers", wr_total - wr_base, 1024);
    push(1'b0, 8'd0, 4'h0);
    push(1'b0, 8'd200, 4'h0);
    chk("R7 re-armed capture", int'(busy), 1);

    // R8 single capture hold
    do_reset();
    hold_mode = 1'b1;
    cfg(2'd0, 8'd100);
    cfg(2'd1, 8'd10);
    push(1'b0, 8'd0, 4'h0);
    push(1'b0, 8'd200, 4'h0);
    mark();
    run_capture();
    chk("R8 done after capture", int'(done), 1);
    chk("R8 busy after capture", int'(busy), 0);
    push(1'b0, 8'd0, 4'h0);
    push(1'b0, 8'd200, 4'h0);
    push(1'b1, 8'd200, 4'h0);
    idle();
    @(posedge clk); #2;
    chk("R8 frozen buffer", wr_total - wr_base, 1024);
    chk("R8 still done", int'(done), 1);
    @(negedge clk);
    hold_mode = 1'b0;
    @(posedge clk); #2;
    chk("R8 released", int'(done), 0);
    push(1'b0, 8'd0, 4'h0);
    push(1'b0, 8'd200, 4'h0);
    chk("R8 re-armed after release", int'(busy), 1);

    // R9 zero fill with limit 1
    do_reset();
    cfg(2'd0, 8'd255);
    cfg(2'd2, 8'd1);
    fill_mode = 1'b1;
    mark();
    for (int k = 0; k < 1023; k++) push(k[0], 8'd0, 4'h0);
    chk("R9 no fill before period end", int'(busy), 0);
    push(1'b1, 8'd0, 4'h0);
    idle();
    chk("R9 fill started", int'(busy), 1);
    repeat (1026) @(posedge clk);
    #2;
    chk("R9 fill write count", wr_total - wr_base, 1024);
    chk("R9 fill address and zero data", mon_err, 0);
    chk("R9 busy after fill", int'(busy), 0);

    // R10 default limit of 4 periods
    do_reset();
    cfg(2'd0, 8'd255);
    mark();
    for (int k = 0; k < 4095; k++) push(k[0], 8'd0, 4'h0);
    chk("R10 default limit not yet reached", int'(busy), 0);
    chk("R10 no writes before limit", wr_total - wr_base, 0);
    push(1'b1, 8'd0, 4'h0);
    idle();
    chk("R10 default limit reached", int'(busy), 1);

    // R10 limit zero disables the fill
    do_reset();
    cfg(2'd0, 8'd255);
    cfg(2'd2, 8'd0);
    mark();
    for (int k = 0; k < 5000; k++) push(k[0], 8'd0, 4'h0);
    idle();
    @(posedge clk); #2;
    chk("R10 disabled fill busy", int'(busy), 0);
    chk("R10 disabled fill writes", wr_total - wr_base, 0);

    summary();
  end

endmodule